// File: doc/BRIEF.md
# Audio Serial Link Frame Transmitter

This block is the outgoing half of a controller for a time-division audio serial link. It is clocked by the link's bit clock. From that clock it derives the frame sync and sends one serial frame per sync period. Each frame begins with a 16-bit tag slot and continues with twelve 20-bit data slots, so a frame lasts 256 bit clocks. With a 12.288 MHz bit clock this gives a 48 kHz frame rate. The tag slot reports which data slots carry a sample in the current frame. Every slot marked empty is sent as all zeros.

Upstream logic hands over a full frame's payload at once: twelve slot words and twelve per-slot valid flags, qualified by a valid/ready handshake. The block offers `in_ready_o` for exactly one cycle per frame, near the end of the frame. A payload taken in that cycle is sent in the following frame. Upstream may hold `in_valid_i` high with its payload for as long as it needs. If no payload is offered in the ready cycle, the next frame goes out with every slot marked empty. A frame-start strobe marks the first tag bit, and upstream can use it as its cue to prepare the next payload. A halt input stops the link for power saving. While halt is high, sync, data, the strobe and ready are driven low and no state moves. When halt is released, the frame carries on from the bit where it stopped.

Top module: `aclink_tx_framer`

## Requirements
- R1: While not halted, `frame_start_o` pulses once every 256 bit clocks (16 + 12 × 20).
- R2: `sync_o` is high for exactly the first 16 bit clocks of each frame and low for the remaining 240.
- R3: Frame bits 0 to 15 form the tag, most-significant bit first. Tag bit 15 is 1 when at least one slot is valid. Tag bit (15 − k) equals the valid flag of slot k, for k = 1 to 12. Tag bits 2 to 0 are 0.
- R4: Slot k's word is `slot_data_i[20(k−1)+19 : 20(k−1)]` and its flag is `slot_valid_i[k−1]`. Word bit b of slot k is sent at frame position 16 + 20(k−1) + (19 − b), so the MSB goes first.
- R5: Every bit of a slot whose latched valid flag is 0 is sent as 0, whatever its data word holds.
- R6: `in_ready_o` is high for one cycle per frame, the cycle in which frame position 254 is on `sdata_o`. If `in_valid_i` is high in that cycle, the payload becomes the content of the next frame. If it is low, the next frame is sent with every flag 0.
- R7: `frame_start_o` is high for one cycle, together with frame position 0, and `sync_o` is high in that cycle.
- R8: While `halt_i` is high, `sync_o`, `sdata_o`, `frame_start_o` and `in_ready_o` are 0 and no state advances. After release, the output continues with the same frame position.
- R9: A synchronous reset drives the outputs low and discards the latched payload. The first rising edge that samples reset low puts frame position 0 on the line, and that first frame is sent with every slot empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link bit clock; outputs change on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| halt_i | input | 1 | Power-save halt: freezes state and silences the link |
| in_valid_i | input | 1 | Upstream offers a frame payload |
| in_ready_o | output | 1 | Payload is taken in this cycle if `in_valid_i` is high |
| slot_valid_i | input | 12 | Per-slot valid flags; bit k−1 belongs to slot k |
| slot_data_i | input | 240 | Twelve 20-bit slot words; slot k at bits 20(k−1)+19 : 20(k−1) |
| sync_o | output | 1 | Frame sync, high during the tag phase |
| sdata_o | output | 1 | Serial frame data, MSB first within each slot |
| frame_start_o | output | 1 | One-cycle strobe on the first tag bit |

## Verification
`sync_o`, `sdata_o` and `frame_start_o` come from registers: each rising edge that is not halted moves them exactly one frame position. `in_ready_o` and the halt silencing are combinational and hold within the same cycle. A payload taken at the edge that ends the ready cycle shows up on the line from the next edge on, beginning with its tag. The bench drives its inputs shortly after each rising edge and compares all four outputs at every falling edge against a 256-bit frame image it computes itself. It advances its own frame position only on cycles it did not halt, so halts placed in the tag phase, in a data slot, on the frame's first bit and over the ready cycle each shift every later result by exactly the number of halted cycles.

// File: rtl/aclink_tx_pkg.sv
`timescale 1ns/1ps
package aclink_tx_pkg;

  localparam int unsigned TAG_BITS_DEF  = 16;
  localparam int unsigned SLOT_CNT_DEF  = 12;
  localparam int unsigned SLOT_BITS_DEF = 20;

  typedef enum logic {
    PH_TAG  = 1'b1,
    PH_DATA = 1'b0
  } phase_e;

  function automatic int unsigned frame_len(input int unsigned tag_w,
                                            input int unsigned slot_n,
                                            input int unsigned slot_w);
    return tag_w + slot_n * slot_w;
  endfunction

endpackage

// File: rtl/aclink_tx_slot_timer.sv
`timescale 1ns/1ps
module aclink_tx_slot_timer #(
  parameter int unsigned TAG_W  = aclink_tx_pkg::TAG_BITS_DEF,
  parameter int unsigned SLOT_N = aclink_tx_pkg::SLOT_CNT_DEF,
  parameter int unsigned SLOT_W = aclink_tx_pkg::SLOT_BITS_DEF,
  parameter int unsigned SIDX_W = 4,
  parameter int unsigned BIDX_W = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 adv_i,
  output logic [SIDX_W-1:0]    slot_idx_o,
  output logic [BIDX_W-1:0]    bit_idx_o,
  output aclink_tx_pkg::phase_e phase_o,
  output logic                 first_bit_o,
  output logic                 last_bit_o
);
  localparam int unsigned FRAME_LEN = aclink_tx_pkg::frame_len(TAG_W, SLOT_N, SLOT_W);
  localparam int unsigned POS_W     = $clog2(FRAME_LEN);

  logic [SIDX_W-1:0] slot_q;
  logic [BIDX_W-1:0] bit_q;

  // slot 0 is the tag, slots 1..SLOT_N carry data; bit index counts down
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      slot_q <= '0;
      bit_q  <= BIDX_W'(TAG_W - 1);
    end else if (adv_i) begin
      if (bit_q == '0) begin
        if (slot_q == SIDX_W'(SLOT_N)) begin
          slot_q <= '0;
          bit_q  <= BIDX_W'(TAG_W - 1);
        end else begin
          slot_q <= slot_q + 1'b1;
          bit_q  <= BIDX_W'(SLOT_W - 1);
        end
      end else begin
        bit_q <= bit_q - 1'b1;
      end
    end
  end

  assign slot_idx_o  = slot_q;
  assign bit_idx_o   = bit_q;
  assign phase_o     = (slot_q == '0) ? aclink_tx_pkg::PH_TAG : aclink_tx_pkg::PH_DATA;
  assign first_bit_o = (slot_q == '0) && (bit_q == BIDX_W'(TAG_W - 1));
  assign last_bit_o  = (slot_q == SIDX_W'(SLOT_N)) && (bit_q == '0);

  // independent linear position counter, used only to cross-check the frame length
  logic [POS_W-1:0] chk_pos_q;
  always_ff @(posedge clk_i) begin
    if (rst_i) chk_pos_q <= '0;
    else if (adv_i) chk_pos_q <= (chk_pos_q == POS_W'(FRAME_LEN - 1)) ? '0 : chk_pos_q + 1'b1;
  end

  assert_frame_len_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    ((chk_pos_q == '0) == first_bit_o));

  assert_bit_range_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    ((slot_q <= SIDX_W'(SLOT_N)) &&
     ((slot_q == '0) ? (bit_q < BIDX_W'(TAG_W)) : (bit_q < BIDX_W'(SLOT_W)))));

endmodule

// File: rtl/aclink_tx_payload_reg.sv
`timescale 1ns/1ps
module aclink_tx_payload_reg #(
  parameter int unsigned TAG_W  = aclink_tx_pkg::TAG_BITS_DEF,
  parameter int unsigned SLOT_N = aclink_tx_pkg::SLOT_CNT_DEF,
  parameter int unsigned SLOT_W = aclink_tx_pkg::SLOT_BITS_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     load_i,
  input  logic                     have_i,
  input  logic [SLOT_N-1:0]        slot_valid_i,
  input  logic [SLOT_N*SLOT_W-1:0] slot_data_i,
  output logic [SLOT_N-1:0]        vld_o,
  output logic [SLOT_N*SLOT_W-1:0] words_o,
  output logic [TAG_W-1:0]         tag_o
);
  logic [SLOT_N-1:0]        vld_q;
  logic [SLOT_N*SLOT_W-1:0] words_q;

  // capture once per frame; an empty offer or an invalid slot stores zeros
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      vld_q   <= '0;
      words_q <= '0;
    end else if (load_i) begin
      for (int k = 0; k < int'(SLOT_N); k++) begin
        vld_q[k] <= have_i & slot_valid_i[k];
        words_q[k*SLOT_W +: SLOT_W] <= (have_i & slot_valid_i[k]) ?
                                       slot_data_i[k*SLOT_W +: SLOT_W] : '0;
      end
    end
  end

  // tag layout: top bit = any slot valid, next SLOT_N bits = slots 1..SLOT_N, rest zero
  for (genvar t = 0; t < TAG_W; t++) begin : g_tag
    if (t == TAG_W - 1) begin : g_any
      assign tag_o[t] = |vld_q;
    end else if (t >= TAG_W - 1 - SLOT_N) begin : g_flag
      assign tag_o[t] = vld_q[TAG_W - 2 - t];
    end else begin : g_pad
      assign tag_o[t] = 1'b0;
    end
  end

  assign vld_o   = vld_q;
  assign words_o = words_q;

endmodule

// File: rtl/aclink_tx_bit_select.sv
`timescale 1ns/1ps
module aclink_tx_bit_select #(
  parameter int unsigned TAG_W  = aclink_tx_pkg::TAG_BITS_DEF,
  parameter int unsigned SLOT_N = aclink_tx_pkg::SLOT_CNT_DEF,
  parameter int unsigned SLOT_W = aclink_tx_pkg::SLOT_BITS_DEF,
  parameter int unsigned SIDX_W = 4,
  parameter int unsigned BIDX_W = 5
) (
  input  logic [SIDX_W-1:0]        slot_idx_i,
  input  logic [BIDX_W-1:0]        bit_idx_i,
  input  logic [TAG_W-1:0]         tag_i,
  input  logic [SLOT_N*SLOT_W-1:0] words_i,
  output logic                     bit_o
);
  localparam int unsigned TIDX_W = (TAG_W > 1) ? $clog2(TAG_W) : 1;
  localparam int unsigned WIDX_W = $clog2(SLOT_N * SLOT_W);

  logic [TIDX_W-1:0] tag_sel;
  logic [WIDX_W-1:0] word_sel;
  int unsigned       word_off;

  always_comb begin
    word_off = (32'(slot_idx_i) - 32'd1) * SLOT_W + 32'(bit_idx_i);
    tag_sel  = TIDX_W'(bit_idx_i);
    word_sel = WIDX_W'(word_off);
    bit_o    = (slot_idx_i == '0) ? tag_i[tag_sel] : words_i[word_sel];
  end

endmodule

// File: rtl/aclink_tx_framer.sv
`timescale 1ns/1ps
module aclink_tx_framer #(
  parameter int unsigned TAG_W  = aclink_tx_pkg::TAG_BITS_DEF,
  parameter int unsigned SLOT_N = aclink_tx_pkg::SLOT_CNT_DEF,
  parameter int unsigned SLOT_W = aclink_tx_pkg::SLOT_BITS_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     halt_i,
  input  logic                     in_valid_i,
  output logic                     in_ready_o,
  input  logic [SLOT_N-1:0]        slot_valid_i,
  input  logic [SLOT_N*SLOT_W-1:0] slot_data_i,
  output logic                     sync_o,
  output logic                     sdata_o,
  output logic                     frame_start_o
);
  localparam int unsigned SIDX_W = $clog2(SLOT_N + 1);
  localparam int unsigned MAX_W  = (TAG_W > SLOT_W) ? TAG_W : SLOT_W;
  localparam int unsigned BIDX_W = $clog2(MAX_W);
  localparam int unsigned PAD_W  = TAG_W - 1 - SLOT_N;
  localparam int unsigned VIDX_W = (SLOT_N > 1) ? $clog2(SLOT_N) : 1;

  logic [SIDX_W-1:0]        slot_idx;
  logic [BIDX_W-1:0]        bit_idx;
  aclink_tx_pkg::phase_e    phase;
  logic                     first_bit, last_bit;
  logic [SLOT_N-1:0]        vld;
  logic [SLOT_N*SLOT_W-1:0] words;
  logic [TAG_W-1:0]         tag;
  logic                     line_bit;
  logic                     adv, ready;
  logic                     sync_q, sd_q, fs_q;

  assign adv   = ~halt_i;
  assign ready = last_bit & ~halt_i & ~rst_i;

  aclink_tx_slot_timer #(
    .TAG_W(TAG_W), .SLOT_N(SLOT_N), .SLOT_W(SLOT_W), .SIDX_W(SIDX_W), .BIDX_W(BIDX_W)
  ) u_timer (
    .clk_i(clk_i), .rst_i(rst_i), .adv_i(adv),
    .slot_idx_o(slot_idx), .bit_idx_o(bit_idx), .phase_o(phase),
    .first_bit_o(first_bit), .last_bit_o(last_bit)
  );

  aclink_tx_payload_reg #(
    .TAG_W(TAG_W), .SLOT_N(SLOT_N), .SLOT_W(SLOT_W)
  ) u_payload (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(ready), .have_i(in_valid_i),
    .slot_valid_i(slot_valid_i), .slot_data_i(slot_data_i),
    .vld_o(vld), .words_o(words), .tag_o(tag)
  );

  aclink_tx_bit_select #(
    .TAG_W(TAG_W), .SLOT_N(SLOT_N), .SLOT_W(SLOT_W), .SIDX_W(SIDX_W), .BIDX_W(BIDX_W)
  ) u_select (
    .slot_idx_i(slot_idx), .bit_idx_i(bit_idx), .tag_i(tag), .words_i(words),
    .bit_o(line_bit)
  );

  // line registers: everything the link sees changes only on a rising edge
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= 1'b0;
      sd_q   <= 1'b0;
      fs_q   <= 1'b0;
    end else if (adv) begin
      sync_q <= (phase == aclink_tx_pkg::PH_TAG);
      sd_q   <= line_bit;
      fs_q   <= first_bit;
    end
  end

  assign sync_o        = sync_q & ~halt_i;
  assign sdata_o       = sd_q & ~halt_i;
  assign frame_start_o = fs_q & ~halt_i;
  assign in_ready_o    = ready;

  // helper for the empty-slot check
  logic [VIDX_W-1:0] vld_sel;
  logic              cur_slot_vld;
  always_comb begin
    vld_sel      = VIDX_W'(slot_idx - 1'b1);
    cur_slot_vld = vld[vld_sel];
  end

  assert_fs_in_sync_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    fs_q |-> sync_q);

  assert_ready_single_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    in_ready_o |=> !in_ready_o);

  assert_halt_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    halt_i |=> ($stable(sync_q) && $stable(sd_q) && $stable(fs_q)));

  assert_empty_slot_zero_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    ((slot_idx != '0) && !cur_slot_vld && !halt_i) |=> !sd_q);

  assert_tag_pad_zero_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    ((slot_idx == '0) && (bit_idx < BIDX_W'(PAD_W)) && !halt_i) |=> !sd_q);

  assert_reset_quiet_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> (!sync_q && !sd_q && !fs_q));

endmodule

// File: tb/sim_aclink_tx_framer.sv
`timescale 1ns/1ps
module sim_aclink_tx_framer;
  localparam int TAG_W  = 16;
  localparam int SLOT_N = 12;
  localparam int SLOT_W = 20;
  localparam int FL     = TAG_W + SLOT_N * SLOT_W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                     rst, halt, in_valid;
  logic [SLOT_N-1:0]        s_valid;
  logic [SLOT_N*SLOT_W-1:0] s_data;
  logic                     in_ready, sync, sdata, fs;

  aclink_tx_framer u0 (
    .clk_i(clk), .rst_i(rst), .halt_i(halt), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .slot_valid_i(s_valid), .slot_data_i(s_data),
    .sync_o(sync), .sdata_o(sdata), .frame_start_o(fs)
  );

  int n_vec, n_bad;
  bit done;
  int pos, fi, gap, halt_left;
  bit seen_fs, mid_rst_done;
  bit trig_done [5];
  logic [FL-1:0]     cur_fr, nxt_fr;
  logic [SLOT_N-1:0] cur_v, nxt_v;
  string             cur_lbl, nxt_lbl;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (frame %0d pos %0d, t=%0t)",
               req, what, act, exp, fi, pos, $time);
    end
  endtask

  function automatic logic [FL-1:0] build(input logic [SLOT_N-1:0] v,
                                          input logic [SLOT_N*SLOT_W-1:0] d);
    logic [FL-1:0] f;
    f = '0;
    f[FL-1] = |v;
    for (int k = 1; k <= SLOT_N; k++) f[FL-1-k] = v[k-1];
    for (int k = 1; k <= SLOT_N; k++)
      for (int b = 0; b < SLOT_W; b++)
        if (v[k-1]) f[FL-1-(TAG_W + SLOT_W*(k-1) + (SLOT_W-1-b))] = d[(k-1)*SLOT_W + b];
    return f;
  endfunction

  task automatic set_payload(input int f);
    case (f)
      0:       s_valid = '1;
      1:       s_valid = '0;
      3:       s_valid = 12'h800;
      5:       s_valid = 12'h001;
      6:       s_valid = '1;
      default: s_valid = 12'((f * 1453 + 241) ^ (f << 5));
    endcase
    for (int k = 0; k < SLOT_N; k++)
      s_data[k*SLOT_W +: SLOT_W] = (f == 6) ? '1 : 20'((k + 1) * 127669 + f * 11121 + k * k * 7);
    in_valid = (f != 4);
  endtask

  task automatic sample_check();
    bit es, ed, ef, er;
    string rq_d, rq_s, rq_f, rq_r;
    if (halt || pos < 0) begin
      es = 0; ed = 0; ef = 0; er = 0;
    end else begin
      es = (pos < TAG_W);
      ef = (pos == 0);
      er = (pos == FL - 2);
      ed = cur_fr[FL-1-pos];
    end
    if (halt) begin
      rq_d = "R8"; rq_s = "R8"; rq_f = "R8"; rq_r = "R8";
    end else if (pos < 0) begin
      rq_d = "R9"; rq_s = "R9"; rq_f = "R9"; rq_r = "R9";
    end else begin
      rq_s = "R2"; rq_f = "R7"; rq_r = "R6";
      if (cur_lbl != "") rq_d = cur_lbl;
      else if (pos < TAG_W) rq_d = "R3";
      else rq_d = cur_v[(pos - TAG_W) / SLOT_W] ? "R4" : "R5";
    end
    chk(sync == es,     rq_s, "sync",        int'(sync),     int'(es));
    chk(sdata == ed,    rq_d, "sdata",       int'(sdata),    int'(ed));
    chk(fs == ef,       rq_f, "frame_start", int'(fs),       int'(ef));
    chk(in_ready == er, rq_r, "in_ready",    int'(in_ready), int'(er));
    if (!halt && pos >= 0) begin
      if (fs) begin
        if (seen_fs) chk(gap == FL, "R1", "frame period", gap, FL);
        seen_fs = 1;
        gap = 0;
      end
      gap++;
    end
    if (!halt) begin
      if (pos == FL - 2) begin
        nxt_fr  = in_valid ? build(s_valid, s_data) : '0;
        nxt_v   = in_valid ? s_valid : '0;
        nxt_lbl = in_valid ? "" : "R6";
      end
      pos++;
      if (pos == FL) pos = 0;
      if (pos == 0) begin
        cur_fr = nxt_fr; cur_v = nxt_v; cur_lbl = nxt_lbl;
        nxt_fr = '0; nxt_v = '0; nxt_lbl = "R6";
        fi++;
      end
    end
  endtask

  task automatic do_reset();
    rst = 1; halt = 0; in_valid = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk(!sync,     "R9", "sync in reset",        int'(sync),     0);
        chk(!sdata,    "R9", "sdata in reset",       int'(sdata),    0);
        chk(!fs,       "R9", "frame_start in reset", int'(fs),       0);
        chk(!in_ready, "R9", "in_ready in reset",    int'(in_ready), 0);
      end
      @(posedge clk);
      #2;
    end
    rst = 0;
    pos = -1;
    nxt_fr = '0; nxt_v = '0; nxt_lbl = "R9";
    seen_fs = 0; gap = 0;
    @(negedge clk);
    sample_check();
  endtask

  initial begin
    n_vec = 0; n_bad = 0; done = 0; halt_left = 0; mid_rst_done = 0;
    rst = 1; halt = 0; in_valid = 0; s_valid = '0; s_data = '0;
    cur_fr = '0; cur_v = '0; cur_lbl = "R9";
    foreach (trig_done[i]) trig_done[i] = 0;
    fi = -1;
    do_reset();
    while (fi < 11) begin
      @(posedge clk);
      #2;
      if (fi == 7 && pos == 130 && !mid_rst_done) begin
        mid_rst_done = 1;
        do_reset();
        continue;
      end
      if (halt_left > 0) begin
        halt = 1; halt_left--;
      end else if (fi == 2 && pos == 5 && !trig_done[0]) begin
        trig_done[0] = 1; halt = 1; halt_left = 2;      // tag phase, 3 cycles
      end else if (fi == 3 && pos == 100 && !trig_done[1]) begin
        trig_done[1] = 1; halt = 1; halt_left = 3;      // inside a data slot, 4 cycles
      end else if (fi == 5 && pos == FL - 2 && !trig_done[2]) begin
        trig_done[2] = 1; halt = 1; halt_left = 4;      // over the ready cycle, 5 cycles
      end else if (fi == 6 && pos == 0 && !trig_done[3]) begin
        trig_done[3] = 1; halt = 1; halt_left = 1;      // on the first tag bit
      end else if (fi == 9 && pos == FL - 1 && !trig_done[4]) begin
        trig_done[4] = 1; halt = 1; halt_left = 1;      // on the last bit
      end else begin
        halt = 0;
      end
      set_payload(fi);
      @(negedge clk);
      sample_check();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL R1 watchdog: actual %0d frames completed expected 11", fi);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule